// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is an I2C target that behaves as a small serial EEPROM. Its storage array is on chip. The system clock oversamples the bus lines SCL and SDA. The block pulls SDA low through an open-drain enable and never drives it high. A three-bit strap input sets the device address. A parameter picks one of two addressing schemes:

- three select bits with a 256-byte array, or
- two select bits plus a page bit carried in the address byte, giving 512 bytes.

A controller can do single-byte or page writes, and current-address, random or sequential reads. Bytes written during a transfer are held in a page buffer. They reach the array only when the controller ends the transfer with a stop condition. While the write-protect input is high, every write is dropped.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: Bus activity is ignored until a start condition is seen (SDA falls while SCL is high). A start at any point aborts the current transfer and waits for a fresh address byte.
- R2: The address byte is received MSB first. Bits 7:4 must be 1010. In two-page mode bits 3:2 must equal dev_sel[2:1]; otherwise bits 3:1 must equal dev_sel. If the byte does not match, there is no acknowledge and SDA is released.
- R3: SDA is pulled low during the ninth clock after a matching address byte. In a write, it is also pulled low after the word-address byte and after every data byte.
- R4: Write data reaches the array only on a stop condition (SDA rises while SCL is high). A start that arrives before the stop discards the pending data.
- R5: While wp is high, write bytes are still acknowledged, but the array is unchanged after the stop.
- R6: In a read (bit 0 of the address byte = 1), the block sends bytes MSB first. After each byte that the controller acknowledges, it sends the byte at the next address.
- R7: If the controller leaves SDA high in the ninth clock of a read byte, the block stops driving and returns to idle.
- R8: After a read that ends at address n, a current-address read returns address n+1. After a write whose last byte went to address n, a current-address read returns address n.
- R9: During a page write, the address advances through the low four bits only and wraps within its 16-byte page.
- R10: A sequential read advances across the whole array and rolls over from 0x1FF to 0x000.
- R11: In two-page mode, bit 1 of a write-mode address byte is word-address bit 8. With 0 a write or random read reaches 0x000–0x0FF; with 1 it reaches 0x100–0x1FF.
- R12: The driven SDA value changes only while SCL is low, following a falling edge of SCL.
- R13: After reset, SDA is released and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| dev_sel | input | 3 | Device address strap; bit 0 is ignored in two-page mode |
| wp | input | 1 | Write protect, 1 blocks writes to the array |

## Verification
A change on SCL or SDA is seen by the block three system clocks later: two synchronizer flops and one edge register. A response on sda_oe then takes one more clock. Acknowledge and read bits therefore appear about four clocks after the SCL falling edge that asks for them. The bench waits a quarter SCL period (ten clocks) after each edge it drives before it samples or drives again. Each read bit is sampled twice during the SCL high phase, and the two samples must agree. A write commit lands one clock after the stop is detected and is observed only through later bus reads.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter bit TWO_PAGE = 1'b1,
  parameter int PAGE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] dev_sel,
  input  logic       wp
);
  localparam int ADDR_W = TWO_PAGE ? 9 : 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PW     = $clog2(PAGE);

  typedef enum logic [2:0] {S_IDLE = 3'd0, S_RX = 3'd1, S_ACK = 3'd2, S_TX = 3'd3, S_RACK = 3'd4} st_t;
  typedef enum logic [1:0] {K_ADDR, K_WORD, K_DATA} kind_t;

  logic [2:0] scl_p, sda_p;
  st_t        st;
  kind_t      kind;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic [ADDR_W-1:0] ptr;
  logic       ps_q, rd, first, mack;
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] pval;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl_rise  = scl_p[1] & ~scl_p[2];
  wire scl_fall  = ~scl_p[1] & scl_p[2];
  wire start_det = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_det  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  wire hit = (sh[7:4] == 4'b1010) &&
             (TWO_PAGE ? (sh[3:2] == dev_sel[2:1]) : (sh[3:1] == dev_sel));
  wire [ADDR_W-1:0] waddr = first ? ptr : {ptr[ADDR_W-1:PW], ptr[PW-1:0] + 1'b1};
  wire [7:0] rd_byte = mem[ptr];
  wire commit = stop_det & ~wp & (|pval);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (pval[i]) mem[{ptr[ADDR_W-1:PW], PW'(i)}] <= pbuf[i];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_ADDR; cnt <= '0; sh <= '0; tx <= '0;
      ptr <= '0; ps_q <= 1'b0; rd <= 1'b0; first <= 1'b0; mack <= 1'b0;
      pval <= '0; sda_oe <= 1'b0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else if (start_det) begin
      st <= S_RX; kind <= K_ADDR; cnt <= '0; sda_oe <= 1'b0; pval <= '0;
    end else if (stop_det) begin
      st <= S_IDLE; sda_oe <= 1'b0; pval <= '0;
    end else begin
      case (st)
        S_RX:
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_p[1]};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == 4'd8) begin
            st <= S_ACK;
            sda_oe <= 1'b1;
            case (kind)
              K_ADDR:
                if (hit) begin
                  rd   <= sh[0];
                  ps_q <= TWO_PAGE ? sh[1] : 1'b0;
                end else begin
                  st <= S_IDLE;
                  sda_oe <= 1'b0;
                end
              K_WORD: begin
                ptr   <= ADDR_W'({ps_q, sh});
                first <= 1'b1;
              end
              default: begin
                ptr <= waddr;
                pbuf[waddr[PW-1:0]] <= sh;
                pval[waddr[PW-1:0]] <= 1'b1;
                first <= 1'b0;
              end
            endcase
          end
        S_ACK:
          if (scl_fall) begin
            if (kind == K_ADDR && rd) begin
              sda_oe <= ~rd_byte[7]; tx <= {rd_byte[6:0], 1'b0}; cnt <= 4'd1; st <= S_TX;
            end else begin
              sda_oe <= 1'b0; st <= S_RX; cnt <= '0;
              kind <= (kind == K_ADDR) ? K_WORD : K_DATA;
            end
          end
        S_TX:
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0; ptr <= ptr + 1'b1; st <= S_RACK;
            end else begin
              sda_oe <= ~tx[7]; tx <= {tx[6:0], 1'b0}; cnt <= cnt + 1'b1;
            end
          end
        S_RACK:
          if (scl_rise) mack <= ~sda_p[1];
          else if (scl_fall) begin
            if (mack) begin
              sda_oe <= ~rd_byte[7]; tx <= {rd_byte[6:0], 1'b0}; cnt <= 4'd1; st <= S_TX;
            end else st <= S_IDLE;
          end
        default: ;
      endcase
    end
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic [2:0]    st_v,
  input logic [3:0]    cnt_v,
  input logic [AW-1:0] ptr_v,
  input logic          start_v
);
  assert_sda_stable_scl_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));

  assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_v == 3'd0) |-> !sda_oe);

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_v) == 3'd3 && st_v == 3'd4) |-> (ptr_v == AW'($past(ptr_v) + 1'b1)));

  assert_start_rearm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_v |=> (st_v == 3'd1 && cnt_v == 4'd0 && !sda_oe));
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.AW(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .st_v(st), .cnt_v(cnt), .ptr_v(ptr), .start_v(start_det)
);

// File: tb/i2c_eeprom_slave_tb_top.sv
module i2c_eeprom_slave_tb_top;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, wp = 1'b0;
  logic sda_oe;
  wire  sda_bus = !(sda_oe || m_low);
  int checks = 0, failures = 0;
  logic [7:0] rbuf [4];
  logic [7:0] wbuf [4];
  logic wack;

  always #5 clk = ~clk;

  i2c_eeprom_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .dev_sel(3'b101), .wp(wp)
  );

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sa(input logic ps, input logic rw);
    return {4'b1010, 2'b10, ps, rw};
  endfunction

  task automatic bstart();
    scl = 1'b0; m_low = 1'b0; hw(Q);
    scl = 1'b1; hw(Q);
    m_low = 1'b1; hw(Q);
    scl = 1'b0; hw(Q);
  endtask

  task automatic bstop();
    scl = 1'b0; m_low = 1'b1; hw(Q);
    scl = 1'b1; hw(Q);
    m_low = 1'b0; hw(Q);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) begin
      m_low = !b[k]; hw(Q);
      scl = 1'b1; hw(2 * Q);
      scl = 1'b0; hw(Q);
    end
    m_low = 1'b0; hw(Q);
    scl = 1'b1; hw(Q);
    ack = !sda_bus; hw(Q);
    scl = 1'b0; hw(Q);
  endtask

  task automatic recv(input logic give_ack, output logic [7:0] d);
    logic s0;
    bit steady = 1'b1;
    for (int k = 0; k < 8; k++) begin
      m_low = 1'b0; hw(Q);
      scl = 1'b1; hw(2);
      s0 = sda_bus; hw(Q - 2);
      d = {d[6:0], sda_bus}; hw(Q - 2);
      if (sda_bus != s0) steady = 1'b0;
      hw(2);
      scl = 1'b0; hw(Q);
    end
    check(steady, "R12 sda steady while scl high", steady, 1);
    m_low = give_ack; hw(Q);
    scl = 1'b1; hw(2 * Q);
    scl = 1'b0; hw(Q);
  endtask

  task automatic wr(input logic ps, input logic [7:0] wa, input int n);
    logic a;
    wack = 1'b1;
    bstart();
    send(sa(ps, 1'b0), a); wack &= a;
    send(wa, a); wack &= a;
    for (int k = 0; k < n; k++) begin send(wbuf[k], a); wack &= a; end
    bstop();
  endtask

  task automatic rread(input logic ps, input logic [7:0] wa, input int n);
    logic a;
    bstart();
    send(sa(ps, 1'b0), a);
    send(wa, a);
    bstart();
    send(sa(ps, 1'b1), a);
    for (int k = 0; k < n; k++) recv(k < n - 1, rbuf[k]);
    bstop();
  endtask

  task automatic cread(input int n);
    logic a;
    bstart();
    send(sa(1'b0, 1'b1), a);
    for (int k = 0; k < n; k++) recv(k < n - 1, rbuf[k]);
    bstop();
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R13 released after reset", sda_oe, 0);
    rread(1'b0, 8'h00, 1);
    check(rbuf[0] == 8'hFF, "R13 word 0x000 erased", rbuf[0], 8'hFF);
    rread(1'b1, 8'hAB, 1);
    check(rbuf[0] == 8'hFF, "R13 word 0x1AB erased", rbuf[0], 8'hFF);
  endtask

  task automatic t_no_start();
    logic a;
    scl = 1'b0; hw(Q);
    send(sa(1'b0, 1'b0), a);
    check(!a, "R1 no ack without start", a, 0);
    bstop();
  endtask

  task automatic t_mismatch();
    logic a;
    bstart(); send(8'hA4, a); bstop();
    check(!a, "R2 select mismatch no ack", a, 0);
    bstart(); send(8'hB8, a); bstop();
    check(!a, "R2 family mismatch no ack", a, 0);
    check(sda_oe == 1'b0, "R2 released after mismatch", sda_oe, 0);
  endtask

  task automatic t_byte_write();
    wbuf[0] = 8'h5A;
    wr(1'b0, 8'h12, 1);
    check(wack, "R3 acks on address word and data", wack, 1);
    rread(1'b0, 8'h12, 1);
    check(rbuf[0] == 8'h5A, "R4 R6 byte write readback", rbuf[0], 8'h5A);
  endtask

  task automatic t_ptr();
    wbuf[0] = 8'h41; wbuf[1] = 8'h42; wbuf[2] = 8'h43;
    wr(1'b0, 8'h40, 3);
    cread(1);
    check(rbuf[0] == 8'h43, "R8 current read after write stays", rbuf[0], 8'h43);
    rread(1'b0, 8'h40, 1);
    check(rbuf[0] == 8'h41, "R8 random read", rbuf[0], 8'h41);
    cread(1);
    check(rbuf[0] == 8'h42, "R8 current read after read is n+1", rbuf[0], 8'h42);
  endtask

  task automatic t_page_wrap();
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    wr(1'b0, 8'h3E, 3);
    rread(1'b0, 8'h30, 1);
    check(rbuf[0] == 8'hA3, "R9 wrap to page start", rbuf[0], 8'hA3);
    rread(1'b0, 8'h3E, 3);
    check(rbuf[0] == 8'hA1, "R9 first byte", rbuf[0], 8'hA1);
    check(rbuf[1] == 8'hA2, "R9 page end byte", rbuf[1], 8'hA2);
    check(rbuf[2] == 8'h41, "R6 sequential crosses page", rbuf[2], 8'h41);
  endtask

  task automatic t_rollover();
    wbuf[0] = 8'hAB; wbuf[1] = 8'hCD;
    wr(1'b1, 8'hFE, 2);
    wbuf[0] = 8'h12;
    wr(1'b0, 8'h00, 1);
    rread(1'b1, 8'hFE, 3);
    check(rbuf[0] == 8'hAB, "R10 byte 0x1FE", rbuf[0], 8'hAB);
    check(rbuf[1] == 8'hCD, "R10 byte 0x1FF", rbuf[1], 8'hCD);
    check(rbuf[2] == 8'h12, "R10 rolls to 0x000", rbuf[2], 8'h12);
  endtask

  task automatic t_page_sel();
    wbuf[0] = 8'h77;
    wr(1'b1, 8'h05, 1);
    rread(1'b0, 8'h05, 1);
    check(rbuf[0] == 8'hFF, "R11 low half untouched", rbuf[0], 8'hFF);
    rread(1'b1, 8'h05, 1);
    check(rbuf[0] == 8'h77, "R11 high half written", rbuf[0], 8'h77);
  endtask

  task automatic t_discard();
    logic a;
    bstart();
    send(sa(1'b0, 1'b0), a);
    send(8'h50, a);
    send(8'h99, a);
    bstart();
    bstop();
    rread(1'b0, 8'h50, 1);
    check(rbuf[0] == 8'hFF, "R4 restart discards pending data", rbuf[0], 8'hFF);
  endtask

  task automatic t_wp();
    wp = 1'b1;
    wbuf[0] = 8'h33;
    wr(1'b0, 8'h60, 1);
    check(wack, "R5 protected write still acked", wack, 1);
    wp = 1'b0;
    rread(1'b0, 8'h60, 1);
    check(rbuf[0] == 8'hFF, "R5 array unchanged", rbuf[0], 8'hFF);
  endtask

  task automatic t_nack();
    logic a;
    logic [7:0] d;
    bit quiet = 1'b1;
    bstart();
    send(sa(1'b0, 1'b0), a);
    send(8'h12, a);
    bstart();
    send(sa(1'b0, 1'b1), a);
    recv(1'b0, d);
    check(d == 8'h5A, "R6 read before nack", d, 8'h5A);
    for (int k = 0; k < 9; k++) begin
      m_low = 1'b0; hw(Q);
      scl = 1'b1; hw(Q);
      if (!sda_bus) quiet = 1'b0;
      hw(Q);
      scl = 1'b0; hw(Q);
    end
    check(quiet, "R7 no drive after nack", quiet, 1);
    bstop();
  endtask

  initial begin
    hw(150000);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    hw(5);
    rst_n = 1'b1;
    hw(5);
    t_reset();
    t_no_start();
    t_mismatch();
    t_byte_write();
    t_ptr();
    t_page_wrap();
    t_rollover();
    t_page_sel();
    t_discard();
    t_wp();
    t_nack();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule